// File: doc/BRIEF.md
# Grouped Output Driver Enable Control

This block sits between a pattern sequencer and the pad ring of a 32-channel digital I/O port. It decides, for every pin and every cycle, which value is presented and whether the pin driver is switched on. The channels form fixed groups of eight. Each group's driver is enabled only when three things agree: the board's channel direction, the sequencer's enable command for that group, and an external enable input for that group. The external enables arrive from outside the clock domain and pass through a two-flop synchronizer.

The channel direction is one setting for the whole board and resets to input. It may be changed only while the machine is halted. A direction write made in Run or Pause is refused and reported with a one-cycle error pulse. Group enables from the sequencer or the external inputs may change at any time, including during Run.

During Run, the incoming vector goes straight to the pins. A register keeps the last vector seen in Run. During Pause that stored vector is presented. During Halt, a configurable policy applies: hold the stored vector, float every pin, or drive zero on enabled pins.

Top module: `grp_drive_ctl`

## Requirements
- R1: After reset the direction is input, so every pin_oe bit is 0. The sequencer group enables reset to all ones. The stored vector resets to zero. dir_err is 0.
- R2: Pin i belongs to group i/8 (pins 0–7 are group 0, 8–15 group 1, 16–23 group 2, 24–31 group 3). All pins of a group share one enable, which is direction AND sequencer enable AND synchronized external enable, apart from the Halt float override in R10.
- R3: With run_state at 0 or 3 (Halt), a dir_wr pulse loads dir_out into the direction setting (1 = output) from the next clock edge onward. No error is flagged.
- R4: With run_state at 1 (Run) or 2 (Pause), a dir_wr pulse leaves the direction unchanged. dir_err is high for exactly the one cycle after the edge that sampled the write.
- R5: A seq_en_wr pulse loads seq_en_val as the sequencer group enables at the next edge, in any state.
- R6: A change on ext_en_raw reaches pin_oe after two clock edges and not after one.
- R7: In Run (run_state 1), pin_out equals vec_in in the same cycle.
- R8: In Pause (run_state 2), pin_out presents the last vector captured in Run, and pin_oe follows the group enables.
- R9: In Halt with halt_mode 0 or 3 (hold), pin_out presents the last Run vector, and pin_oe follows the group enables.
- R10: In Halt with halt_mode 1 (float), every pin_oe bit is 0.
- R11: In Halt with halt_mode 2 (zero), pin_out is all zeros, and pin_oe follows the group enables.
- R12: The stored vector is updated only by clock edges in Run. vec_in seen in Pause or Halt never alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_state | input | 2 | Machine state: 0 Halt, 1 Run, 2 Pause, 3 Halt |
| vec_in | input | NCH | Vector from pattern memory |
| seq_en_wr | input | 1 | Sequencer group-enable command strobe |
| seq_en_val | input | NGRP | Group enables carried by the command |
| ext_en_raw | input | NGRP | Asynchronous external group enables |
| dir_wr | input | 1 | Direction write strobe |
| dir_out | input | 1 | Direction value, 1 = output |
| halt_mode | input | 2 | Halt policy: 0/3 hold, 1 float, 2 zero |
| pin_out | output | NCH | Value to the pin drivers |
| pin_oe | output | NCH | Per-pin driver enable |
| dir_err | output | 1 | One-cycle pulse for a refused direction write |

## Verification
A sequencer enable command and a direction write can arrive in the same cycle. The bench provokes this during Run by pulsing seq_en_wr and dir_wr together. It then judges the cycle that follows: the new group enables must appear on pin_oe, dir_err must pulse, and direction must still be output. A second collision repeats this in Pause, combined with a change on the external enables. Separately, the bench sweeps all 256 pairs of sequencer and external enable masks and checks pin_oe against the arithmetic AND of the masks, expanded eight pins per group.

// File: rtl/grp_drive_ctl.sv
module grp_drive_ctl #(
  parameter int NGRP = 4,
  parameter int GW   = 8,
  localparam int NCH = NGRP * GW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      run_state,
  input  logic [NCH-1:0]  vec_in,
  input  logic            seq_en_wr,
  input  logic [NGRP-1:0] seq_en_val,
  input  logic [NGRP-1:0] ext_en_raw,
  input  logic            dir_wr,
  input  logic            dir_out,
  input  logic [1:0]      halt_mode,
  output logic [NCH-1:0]  pin_out,
  output logic [NCH-1:0]  pin_oe,
  output logic            dir_err
);
  localparam logic [1:0] ST_RUN    = 2'd1;
  localparam logic [1:0] ST_PAUSE  = 2'd2;
  localparam logic [1:0] MODE_HIZ  = 2'd1;
  localparam logic [1:0] MODE_ZERO = 2'd2;

  logic            dir_q;
  logic [NGRP-1:0] seq_q, ext_s1, ext_s2, grp_en, grp_oe;
  logic [NCH-1:0]  last_q;
  logic            is_run, is_halt;

  assign is_run  = (run_state == ST_RUN);
  assign is_halt = !is_run && (run_state != ST_PAUSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      dir_err <= 1'b0;
      seq_q   <= '1;
      ext_s1  <= '0;
      ext_s2  <= '0;
      last_q  <= '0;
    end else begin
      ext_s1  <= ext_en_raw;
      ext_s2  <= ext_s1;
      dir_err <= dir_wr && !is_halt;
      if (dir_wr && is_halt) dir_q <= dir_out;
      if (seq_en_wr) seq_q <= seq_en_val;
      if (is_run) last_q <= vec_in;
    end
  end

  assign grp_en = {NGRP{dir_q}} & seq_q & ext_s2;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_oe[g] = grp_en[g] && !(is_halt && halt_mode == MODE_HIZ);
    assign pin_oe[g*GW +: GW] = {GW{grp_oe[g]}};
  end

  assign pin_out = is_run ? vec_in :
                   (is_halt && halt_mode == MODE_ZERO) ? '0 : last_q;
endmodule

// File: rtl/grp_drive_ctl_chk.sv
module grp_drive_ctl_chk #(
  parameter int NGRP = 4,
  parameter int GW   = 8,
  localparam int NCH = NGRP * GW
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      run_state,
  input logic [NCH-1:0]  vec_in,
  input logic            seq_en_wr,
  input logic [NGRP-1:0] seq_en_val,
  input logic            dir_wr,
  input logic [1:0]      halt_mode,
  input logic [NCH-1:0]  pin_out,
  input logic [NCH-1:0]  pin_oe,
  input logic            dir_err
);
  AST_DIR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr && (run_state == 2'd1 || run_state == 2'd2) |=> dir_err); // R4
  AST_DIR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr && (run_state == 2'd0 || run_state == 2'd3) |=> !dir_err); // R3
  AST_RUN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd1 |-> pin_out == vec_in); // R7
  AST_HALT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd0 && halt_mode == 2'd1 |-> pin_oe == '0); // R10
  AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd0 && halt_mode == 2'd2 |-> pin_out == '0); // R11
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd2 && $past(run_state) == 2'd2 |-> $stable(pin_out)); // R12
  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    AST_SEQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      seq_en_wr && !seq_en_val[g] |=> pin_oe[g*GW +: GW] == '0); // R5
  end
endmodule

bind grp_drive_ctl grp_drive_ctl_chk #(.NGRP(NGRP), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_state(run_state), .vec_in(vec_in),
  .seq_en_wr(seq_en_wr), .seq_en_val(seq_en_val), .dir_wr(dir_wr),
  .halt_mode(halt_mode), .pin_out(pin_out), .pin_oe(pin_oe), .dir_err(dir_err));

// File: tb/sim_grp_drive_ctl.sv
module sim_grp_drive_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  run_state = 2'd0;
  logic [31:0] vec_in = '0;
  logic        seq_en_wr = 1'b0;
  logic [3:0]  seq_en_val = '0;
  logic [3:0]  ext_en_raw = '0;
  logic        dir_wr = 1'b0;
  logic        dir_out = 1'b0;
  logic [1:0]  halt_mode = 2'd0;
  logic [31:0] pin_out, pin_oe;
  logic        dir_err;
  int tot = 0;
  int bad = 0;

  always #5 clk = ~clk;

  grp_drive_ctl u0 (.*);

  function automatic logic [31:0] spread(input logic [3:0] m);
    logic [31:0] r = '0;
    for (int g = 0; g < 4; g++) if (m[g]) r[g*8 +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tot++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic seq_cmd(input logic [3:0] m);
    seq_en_wr = 1'b1; seq_en_val = m;
    tick();
    seq_en_wr = 1'b0;
  endtask

  task automatic dir_cmd(input logic d);
    dir_wr = 1'b1; dir_out = d;
    tick();
    dir_wr = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    #1;
    chk("R1 oe after reset", pin_oe, 32'h0);
    chk("R1 err after reset", {31'b0, dir_err}, 32'h0);
    chk("R1 stored vector zero", pin_out, 32'h0);

    ext_en_raw = 4'hF;
    tick(); tick();
    chk("R1 input dir keeps oe off", pin_oe, 32'h0);
    dir_cmd(1'b1);
    chk("R3 halt dir write accepted", pin_oe, 32'hFFFF_FFFF);
    chk("R3 no error in halt", {31'b0, dir_err}, 32'h0);

    ext_en_raw = 4'h0;
    tick();
    chk("R6 one edge not yet", pin_oe, 32'hFFFF_FFFF);
    tick();
    chk("R6 two edges applied", pin_oe, 32'h0);

    run_state = 2'd1;
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        vec_in = {4{s[3:0], e[3:0]}} ^ 32'h5A5A_0F0F;
        seq_cmd(s[3:0]);
        ext_en_raw = e[3:0];
        tick(); tick();
        chk("R2 R5 group enable sweep", pin_oe, spread(s[3:0] & e[3:0]));
        chk("R7 run passthrough", pin_out, vec_in);
      end
    end

    ext_en_raw = 4'hF;
    seq_cmd(4'hF);
    tick();
    vec_in = 32'hCAFE_0123;
    tick();
    seq_en_wr = 1'b1; seq_en_val = 4'h6; dir_wr = 1'b1; dir_out = 1'b0;
    tick();
    seq_en_wr = 1'b0; dir_wr = 1'b0;
    chk("R4 run dir write flagged", {31'b0, dir_err}, 32'h1);
    chk("R4 R5 collision oe", pin_oe, spread(4'h6));
    tick();
    chk("R4 error one cycle", {31'b0, dir_err}, 32'h0);
    chk("R4 direction kept", pin_oe, spread(4'h6));

    run_state = 2'd2;
    vec_in = 32'h1111_2222;
    #1;
    chk("R8 pause shows last run vector", pin_out, 32'hCAFE_0123);
    chk("R8 pause oe", pin_oe, spread(4'h6));
    tick(); tick();
    chk("R12 pause does not capture", pin_out, 32'hCAFE_0123);
    seq_en_wr = 1'b1; seq_en_val = 4'hF; dir_wr = 1'b1; dir_out = 1'b0;
    ext_en_raw = 4'h9;
    tick();
    seq_en_wr = 1'b0; dir_wr = 1'b0;
    chk("R4 pause dir write flagged", {31'b0, dir_err}, 32'h1);
    tick();
    chk("R6 R5 pause collision oe", pin_oe, spread(4'h9));

    run_state = 2'd0;
    for (int m = 0; m < 4; m++) begin
      halt_mode = m[1:0];
      vec_in = 32'h3333_0000 + m;
      tick();
      case (m)
        1: begin
          chk("R10 float oe", pin_oe, 32'h0);
          chk("R12 float value", pin_out, 32'hCAFE_0123);
        end
        2: begin
          chk("R11 zero value", pin_out, 32'h0);
          chk("R11 zero oe", pin_oe, spread(4'h9));
        end
        default: begin
          chk("R9 hold value", pin_out, 32'hCAFE_0123);
          chk("R9 hold oe", pin_oe, spread(4'h9));
        end
      endcase
    end

    halt_mode = 2'd0;
    dir_cmd(1'b0);
    chk("R3 halt switch to input", pin_oe, 32'h0);
    chk("R3 no error", {31'b0, dir_err}, 32'h0);

    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule